// File: doc/BRIEF.md
# Analog Front-End Nibble and Control-Word Link

This block sits between a transceiver core and an external analog front end, all on one master clock. Sample data crosses in both directions as 4-bit nibbles, one per clock, each passing through a single register stage. A narrow serial channel carries 16-bit control words out to the front end and 16-bit status words back. That channel is framed by a word-clock input from the front end. The word clock pulses once every four master clocks and marks the first bit of each 4-bit group.

A control word is sent MSB first as four back-to-back groups of four bits. The core pulses a start strobe with the word. The block holds the word while busy, waits for the next word-clock pulse, and then shifts one bit per clock. Status bits from the front end are gathered the same way into a 16-bit word, and the block pulses a valid flag for one cycle when the word is complete.

The write-strobe pin and the control-data-in pin are shared with general-purpose I/O. A configuration bit from a register outside the block chooses between the two functions, and after reset the pins act as general-purpose I/O. The block also registers the front-end reset, front-end power-down and line-driver power-down outputs. These hold the front end in reset and powered down for as long as reset lasts.

Top module: `afe_link`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `tx_nib_o` is 0, `ctl_dout_o` is 1, `ctl_busy_o` is 0, `afe_pwdn_o` and `ld_pwdn_o` are 1, and `afe_rst_n_o` is 0.
- R2: `tx_nib_o` equals the value `tx_nib_i` held one clock earlier.
- R3: `rx_nib_o` equals the value `rx_nib_pin_i` held one clock earlier.
- R4: A start strobe while idle captures `ctl_word_i` and raises `ctl_busy_o` in the next cycle. A start strobe while busy is ignored: the word in flight is not changed, and no second transfer follows.
- R5: At the first clock edge with `word_clk_i` high while busy, bit 15 of the word appears on `ctl_dout_o`. Bits 14 down to 0 follow on the next 15 clocks, with no gaps.
- R6: At the clock after bit 0, `ctl_dout_o` returns to 1 and `ctl_busy_o` falls in the same cycle. `ctl_dout_o` is 1 whenever no bit is being shifted.
- R7: With `afe_sel_i`=1, the bit on `pin_din_i` at a clock edge with `word_clk_i` high is bit 15 of a status word, and the next 15 clocks carry bits 14..0. One cycle after bit 0, `sts_word_o` holds the word and `sts_valid_o` is 1 for exactly one cycle.
- R8: With `afe_sel_i`=1, `pin_wr_oe_o` is 1, and `pin_wr_o` is 0 exactly in the cycles in which `ctl_dout_o` carries a word bit, otherwise 1. With `afe_sel_i`=0, `pin_wr_o` follows `gpio_wr_out_i` and `pin_wr_oe_o` follows `gpio_wr_oe_i`.
- R9: With `afe_sel_i`=0, `gpio_din_o` is `pin_din_i` delayed by one clock, and no status word is assembled (`sts_valid_o` stays 0). With `afe_sel_i`=1, `gpio_din_o` reads 0.
- R10: `afe_rst_n_o` is the inverse of `afe_rst_req_i`, and `afe_pwdn_o` and `ld_pwdn_o` equal their request inputs. Each output follows its input after one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_nib_i | input | 4 | Transmit nibble from the core |
| tx_nib_o | output | 4 | Registered transmit nibble to the front end |
| rx_nib_pin_i | input | 4 | Receive nibble from the front end |
| rx_nib_o | output | 4 | Registered receive nibble to the core |
| word_clk_i | input | 1 | Group-start pulse from the front end, one clock in four |
| ctl_start_i | input | 1 | Start strobe for a control word |
| ctl_word_i | input | 16 | Control word to send |
| ctl_busy_o | output | 1 | Control word held or being shifted |
| ctl_dout_o | output | 1 | Serial control data, idles high |
| sts_word_o | output | 16 | Last complete status word |
| sts_valid_o | output | 1 | One-cycle pulse when a status word completes |
| afe_sel_i | input | 1 | 1: shared pins serve the front end; 0: general-purpose I/O |
| gpio_wr_out_i | input | 1 | GPIO output value for the write-strobe pin |
| gpio_wr_oe_i | input | 1 | GPIO output enable for the write-strobe pin |
| pin_wr_o | output | 1 | Write-strobe / GPIO pin output value |
| pin_wr_oe_o | output | 1 | Write-strobe / GPIO pin output enable |
| pin_din_i | input | 1 | Control-data-in / GPIO pin |
| gpio_din_o | output | 1 | Registered GPIO read of the data-in pin |
| afe_rst_req_i | input | 1 | Request to hold the front end in reset |
| afe_pwdn_req_i | input | 1 | Request to power down the front end |
| ld_pwdn_req_i | input | 1 | Request to power down the line driver |
| afe_rst_n_o | output | 1 | Front-end reset, active low |
| afe_pwdn_o | output | 1 | Front-end power-down |
| ld_pwdn_o | output | 1 | Line-driver power-down |

## Verification
The assertions check on every cycle that the serial output stays high unless a bit is being shifted. They also check that a held word waits for a word-clock pulse, that a shift, once started, runs to its last bit, and that the status valid flag lasts one cycle and never fires in GPIO mode. Per-cycle checks also cover the write-strobe enable and the one-clock latency of the power controls. Only the bench's scenarios can show the bit order and the exact cycle of the first and last bit against the word-clock pulse. They also show that a start strobe arriving mid-word is dropped, that assembled status words carry the right value, and the pin routing in each mode.

// File: rtl/afe_link_pkg.sv
package afe_link_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  localparam logic SER_IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/afe_ctl_tx.sv
module afe_ctl_tx
  import afe_link_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_i,
  output logic              busy_o,
  output logic              shifting_o,
  output logic              dout_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  tx_state_e         state_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      dout_q  <= SER_IDLE_LEVEL;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            sh_q    <= word_i;
            state_q <= TX_ARMED;
          end
        end
        TX_ARMED: begin
          if (frame_i) begin
            dout_q  <= sh_q[WORD_W-1];
            sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q   <= LAST_CNT;
            state_q <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (cnt_q != '0) begin
            dout_q <= sh_q[WORD_W-1];
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q  <= cnt_q - 1'b1;
          end else begin
            dout_q  <= SER_IDLE_LEVEL;
            state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != TX_IDLE);
  assign shifting_o = (state_q == TX_SHIFT);
  assign dout_o     = dout_q;

  a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state_q != TX_SHIFT) |-> dout_q);
  a_r4_no_spontaneous_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_IDLE && !start_i) |=> (state_q == TX_IDLE));
  a_r5_wait_for_frame: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_ARMED && !frame_i) |=> (state_q == TX_ARMED));
  a_r5_shift_runs_on: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_SHIFT && cnt_q != '0) |=> (state_q == TX_SHIFT));
endmodule

// File: rtl/afe_ctl_rx.sv
module afe_ctl_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              frame_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic              on_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else if (!on_q) begin
        if (frame_i) begin
          sh_q  <= {sh_q[WORD_W-2:0], din_i};
          cnt_q <= CNT_W'(1);
          on_q  <= 1'b1;
        end
      end else begin
        sh_q <= {sh_q[WORD_W-2:0], din_i};
        if (cnt_q == LAST_CNT) begin
          word_q  <= {sh_q[WORD_W-2:0], din_i};
          valid_q <= 1'b1;
          on_q    <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  a_r9_quiet_in_gpio: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !valid_q);
endmodule

// File: rtl/afe_pin_mux.sv
module afe_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic afe_sel_i,
  input  logic shifting_i,
  input  logic gpio_wr_out_i,
  input  logic gpio_wr_oe_i,
  input  logic pin_din_i,
  output logic pin_wr_o,
  output logic pin_wr_oe_o,
  output logic gpio_din_o
);
  logic gpio_din_q;

  always_ff @(posedge clk) begin
    if (rst) gpio_din_q <= 1'b0;
    else     gpio_din_q <= afe_sel_i ? 1'b0 : pin_din_i;
  end

  assign pin_wr_o    = afe_sel_i ? ~shifting_i : gpio_wr_out_i;
  assign pin_wr_oe_o = afe_sel_i ? 1'b1 : gpio_wr_oe_i;
  assign gpio_din_o  = gpio_din_q;

  a_r8_strobe_driven: assert property (@(posedge clk) disable iff (rst)
    (afe_sel_i && shifting_i) |-> (pin_wr_oe_o && !pin_wr_o));
  a_r9_gpio_read_masked: assert property (@(posedge clk) disable iff (rst)
    afe_sel_i |=> !gpio_din_o);
endmodule

// File: rtl/afe_link.sv
module afe_link #(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  tx_nib_i,
  output logic [NIB_W-1:0]  tx_nib_o,
  input  logic [NIB_W-1:0]  rx_nib_pin_i,
  output logic [NIB_W-1:0]  rx_nib_o,
  input  logic              word_clk_i,
  input  logic              ctl_start_i,
  input  logic [WORD_W-1:0] ctl_word_i,
  output logic              ctl_busy_o,
  output logic              ctl_dout_o,
  output logic [WORD_W-1:0] sts_word_o,
  output logic              sts_valid_o,
  input  logic              afe_sel_i,
  input  logic              gpio_wr_out_i,
  input  logic              gpio_wr_oe_i,
  output logic              pin_wr_o,
  output logic              pin_wr_oe_o,
  input  logic              pin_din_i,
  output logic              gpio_din_o,
  input  logic              afe_rst_req_i,
  input  logic              afe_pwdn_req_i,
  input  logic              ld_pwdn_req_i,
  output logic              afe_rst_n_o,
  output logic              afe_pwdn_o,
  output logic              ld_pwdn_o
);
  logic [NIB_W-1:0] tx_nib_q, rx_nib_q;
  logic             rst_n_q, pwdn_q, ld_pwdn_q;
  logic             shifting;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_nib_q  <= '0;
      rx_nib_q  <= '0;
      rst_n_q   <= 1'b0;
      pwdn_q    <= 1'b1;
      ld_pwdn_q <= 1'b1;
    end else begin
      tx_nib_q  <= tx_nib_i;
      rx_nib_q  <= rx_nib_pin_i;
      rst_n_q   <= ~afe_rst_req_i;
      pwdn_q    <= afe_pwdn_req_i;
      ld_pwdn_q <= ld_pwdn_req_i;
    end
  end

  assign tx_nib_o    = tx_nib_q;
  assign rx_nib_o    = rx_nib_q;
  assign afe_rst_n_o = rst_n_q;
  assign afe_pwdn_o  = pwdn_q;
  assign ld_pwdn_o   = ld_pwdn_q;

  afe_ctl_tx #(.WORD_W(WORD_W)) i_tx (
    .clk(clk), .rst(rst), .start_i(ctl_start_i), .word_i(ctl_word_i),
    .frame_i(word_clk_i), .busy_o(ctl_busy_o), .shifting_o(shifting),
    .dout_o(ctl_dout_o)
  );

  afe_ctl_rx #(.WORD_W(WORD_W)) i_rx (
    .clk(clk), .rst(rst), .en_i(afe_sel_i), .frame_i(word_clk_i),
    .din_i(pin_din_i), .word_o(sts_word_o), .valid_o(sts_valid_o)
  );

  afe_pin_mux i_mux (
    .clk(clk), .rst(rst), .afe_sel_i(afe_sel_i), .shifting_i(shifting),
    .gpio_wr_out_i(gpio_wr_out_i), .gpio_wr_oe_i(gpio_wr_oe_i),
    .pin_din_i(pin_din_i), .pin_wr_o(pin_wr_o), .pin_wr_oe_o(pin_wr_oe_o),
    .gpio_din_o(gpio_din_o)
  );

  a_r10_pwdn_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (afe_pwdn_o == $past(afe_pwdn_req_i)));
  a_r10_ld_pwdn_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ld_pwdn_o == $past(ld_pwdn_req_i)));
endmodule

// File: tb/test_afe_link.sv
module test_afe_link;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [3:0]  tx_nib_i = '0, rx_nib_pin_i = '0;
  logic [3:0]  tx_nib_o, rx_nib_o;
  logic        word_clk_i = 1'b0, ctl_start_i = 1'b0;
  logic [15:0] ctl_word_i = '0;
  logic        ctl_busy_o, ctl_dout_o, sts_valid_o;
  logic [15:0] sts_word_o;
  logic        afe_sel_i = 1'b0, gpio_wr_out_i = 1'b0, gpio_wr_oe_i = 1'b0;
  logic        pin_wr_o, pin_wr_oe_o, pin_din_i = 1'b0, gpio_din_o;
  logic        afe_rst_req_i = 1'b1, afe_pwdn_req_i = 1'b1, ld_pwdn_req_i = 1'b1;
  logic        afe_rst_n_o, afe_pwdn_o, ld_pwdn_o;

  afe_link i_afe_link (.*);

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [15:0] TXW [4] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'h1234};
  localparam logic [15:0] RXW [4] = '{16'h3C5A, 16'hFFFF, 16'h0001, 16'hB00D};
  localparam logic [3:0]  TXN [4] = '{4'h9, 4'hF, 4'h0, 4'h6};
  localparam logic [3:0]  RXN [4] = '{4'h3, 4'hA, 4'hF, 4'h5};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_word(input logic [15:0] w);
    @(negedge clk);
    ctl_start_i = 1'b1;
    ctl_word_i  = w;
    @(negedge clk);
    ctl_start_i = 1'b0;
    check("R4 busy after start", 16'(ctl_busy_o), 16'h1);
  endtask

  // 16-cycle framed window plus two trailing cycles; word clock every 4th cycle
  task automatic run_frame(input logic [15:0] txw, input logic [15:0] rxw,
                           input bit chk_tx, input bit afe);
    for (int j = 0; j < 18; j++) begin
      @(negedge clk);
      if (chk_tx && j >= 1 && j <= 16) begin
        check("R5 serial bit", 16'(ctl_dout_o), 16'(txw[16-j]));
        if (afe) check("R8 strobe low while shifting", 16'(pin_wr_o), 16'h0);
      end
      if (chk_tx && j == 17) begin
        check("R6 idle high after word", 16'(ctl_dout_o), 16'h1);
        check("R6 busy cleared", 16'(ctl_busy_o), 16'h0);
        if (afe) check("R8 strobe released", 16'(pin_wr_o), 16'h1);
      end
      if (!chk_tx && j >= 1)
        check("R6 idle when no word", 16'(ctl_dout_o), 16'h1);
      if (j == 16) begin
        check("R7 status valid pulse", 16'(sts_valid_o), 16'(afe));
        if (afe) check("R7 status word", sts_word_o, rxw);
      end else if (j >= 1) begin
        check("R7 R9 no stray valid", 16'(sts_valid_o), 16'h0);
      end
      if (j < 16) begin
        word_clk_i = (j % 4 == 0);
        pin_din_i  = rxw[15-j];
      end else begin
        word_clk_i = 1'b0;
        pin_din_i  = 1'b0;
      end
      // R4: a start strobe in mid-word must be dropped
      ctl_start_i = chk_tx && (j == 5);
      ctl_word_i  = ~txw;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1 tx nibble", 16'(tx_nib_o), 16'h0);
    check("R1 dout idle", 16'(ctl_dout_o), 16'h1);
    check("R1 busy", 16'(ctl_busy_o), 16'h0);
    check("R1 afe pwdn", 16'(afe_pwdn_o), 16'h1);
    check("R1 ld pwdn", 16'(ld_pwdn_o), 16'h1);
    check("R1 afe reset", 16'(afe_rst_n_o), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pwdn held after reset", 16'(afe_pwdn_o), 16'h1);
    check("R1 afe reset held", 16'(afe_rst_n_o), 16'h0);

    // R10: power controls, one clock latency
    afe_rst_req_i = 1'b0; afe_pwdn_req_i = 1'b0;
    @(negedge clk);
    check("R10 afe reset released", 16'(afe_rst_n_o), 16'h1);
    check("R10 afe powered", 16'(afe_pwdn_o), 16'h0);
    check("R10 ld pwdn unchanged", 16'(ld_pwdn_o), 16'h1);
    ld_pwdn_req_i = 1'b0;
    @(negedge clk);
    check("R10 ld powered", 16'(ld_pwdn_o), 16'h0);

    // R8, R9: GPIO mode
    gpio_wr_out_i = 1'b1; gpio_wr_oe_i = 1'b1; pin_din_i = 1'b1;
    @(negedge clk);
    check("R8 gpio value", 16'(pin_wr_o), 16'h1);
    check("R8 gpio enable", 16'(pin_wr_oe_o), 16'h1);
    check("R9 gpio read", 16'(gpio_din_o), 16'h1);
    gpio_wr_out_i = 1'b0; gpio_wr_oe_i = 1'b0; pin_din_i = 1'b0;
    @(negedge clk);
    check("R8 gpio value low", 16'(pin_wr_o), 16'h0);
    check("R8 gpio enable low", 16'(pin_wr_oe_o), 16'h0);
    check("R9 gpio read low", 16'(gpio_din_o), 16'h0);
    run_frame(16'h0, 16'hFFFF, 1'b0, 1'b0);   // R9: no status word in GPIO mode

    // switch to front-end mode
    afe_sel_i = 1'b1; pin_din_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 gpio read masked", 16'(gpio_din_o), 16'h0);
    check("R8 strobe enabled", 16'(pin_wr_oe_o), 16'h1);
    check("R8 strobe idle high", 16'(pin_wr_o), 16'h1);
    pin_din_i = 1'b0;

    // vector table walk: nibbles plus one control word and one status word each
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      tx_nib_i = TXN[v]; rx_nib_pin_i = RXN[v];
      @(negedge clk);
      check("R2 tx nibble", 16'(tx_nib_o), 16'(TXN[v]));
      check("R3 rx nibble", 16'(rx_nib_o), 16'(RXN[v]));
      start_word(TXW[v]);
      // R4/R5: armed word waits with no word clock
      repeat (3) @(negedge clk);
      check("R5 wait for word clock", 16'(ctl_dout_o), 16'h1);
      check("R4 still busy", 16'(ctl_busy_o), 16'h1);
      run_frame(TXW[v], RXW[v], 1'b1, 1'b1);
    end

    // status word only, no control word pending
    run_frame(16'h0, 16'h5A96, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule